// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block keeps a microcontroller core in reset after power is applied. It runs two waits in turn. The first is a power-up delay counted on a slow tick from an internal RC source. The second is a start-up count of crystal clock cycles, which gives the oscillator time to settle. The analog supply detector and the oscillators are outside the block. A power-on event arrives as a synchronous active-low pulse, `por_n`, which both clock domains sample. A new pulse at any point restarts the whole sequence from the beginning.

The crystal count runs only in the three crystal modes. It runs after a power-on event, and it runs again when a wake-from-sleep pulse arrives. In the RC and external-clock mode the crystal count is skipped. Reset then releases as soon as the delay's completion flag has crossed into the crystal domain. That crossing uses a two-flop synchroniser.

The external active-low reset pin gates the released state without any clocking. If the pin is held low until both waits have finished, raising it frees the core at once. Enabling brown-out protection forces the power-up delay on, whatever the state of its own enable.

Top module: `prst_timeout_seq`

## Requirements
- R1: While `por_n` is low, and throughout both waits, `core_rst_n` is 0.
- R2: With the delay enabled, the completion flag is set on the PWRT_TICKS-th `clk_slow` rising edge after `por_n` returns high. In RC/external mode (`osc_mode` = 2'b11), `core_rst_n` then rises on the 3rd `clk_osc` rising edge after that slow edge.
- R3: In the crystal modes (`osc_mode` 2'b00 low-power, 2'b01 standard, 2'b10 high-speed), `core_rst_n` rises on the (OST_CYCLES+2)-th `clk_osc` rising edge after the delay completes.
- R4: With `pwrt_en` = 0 and `bor_en` = 0 there is no delay. The R2 and R3 edge counts then start from the moment `por_n` returns high.
- R5: `bor_en` = 1 forces the delay on even when `pwrt_en` = 0, with the same timing as R2 and R3.
- R6: `core_rst_n` is 1 only while `mclr_n` is 1. If both waits have finished, a rise of `mclr_n` raises `core_rst_n` with no clock edge.
- R7: In a crystal mode, a `wake` pulse sampled on `clk_osc` edge w drops `core_rst_n` after edge w. It restarts the crystal count, and `core_rst_n` rises again on edge w+OST_CYCLES.
- R8: In RC/external mode, `wake` has no effect on `core_rst_n`.
- R9: A new low pulse on `por_n` during either wait restarts the sequence from the power-up delay. Release timing is then counted from the new pulse's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow internal RC tick clocking the power-up delay |
| clk_osc | input | 1 | Crystal / external oscillator clock |
| por_n | input | 1 | Active-low power-on pulse, synchronous restart of both domains |
| wake | input | 1 | Wake-from-sleep pulse, synchronous to clk_osc |
| mclr_n | input | 1 | External active-low reset pin |
| osc_mode | input | 2 | 00 low-power crystal, 01 crystal, 10 high-speed crystal, 11 RC/external |
| pwrt_en | input | 1 | Enables the power-up delay |
| bor_en | input | 1 | Brown-out protection enable; forces the delay on |
| core_rst_n | output | 1 | Active-low reset to the core |

## Verification
The assertions assume the following about the block's inputs:
- `osc_mode`, `pwrt_en` and `bor_en` are static whenever `por_n` is high.
- `wake` is a single-cycle pulse synchronous to `clk_osc`.
- `por_n` is held low across several edges of both clocks.

The stimulus keeps within these limits. It changes the configuration only after it has pulled `por_n` low. It drives every input one time unit after a falling edge of `clk_osc`. It places the `clk_slow` edges on `clk_osc` falling edges, so the completion flag never changes at the instant the synchroniser samples it. This keeps every release cycle exact and predictable.

// File: rtl/prst_pkg.sv
// Shared types for the power-up reset timeout sequencer.
// Assumes: the oscillator mode is a 2-bit code fixed while por_n is high.
package prst_pkg;

    typedef enum logic [1:0] {
        OSC_LOWPWR = 2'b00,
        OSC_XTAL   = 2'b01,
        OSC_FAST   = 2'b10,
        OSC_RCEXT  = 2'b11
    } osc_mode_e;

    // True when the mode drives a crystal that needs a start-up count.
    function automatic logic needs_startup(input osc_mode_e m);
        return (m != OSC_RCEXT);
    endfunction

endpackage

// File: rtl/prst_pwrt_timer.sv
// Power-up delay counter on the slow RC tick.
// Counts TICKS slow edges after por_n returns high and then sets done.
// When the delay is off, done is already set while por_n is low.
// Assumes: delay_on is static while por_n is high.
module prst_pwrt_timer #(
    parameter int TICKS = 2048
) (
    input  logic clk_slow,
    input  logic por_n,
    input  logic delay_on,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    // Count slow ticks up to the delay length, then hold done.
    always_ff @(posedge clk_slow) begin
        if (!por_n) begin
            cnt  <= '0;
            done <= !delay_on;
        end else if (!done) begin
            if (cnt == LAST) done <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end

    a_r2_done_holds: assert property (@(posedge clk_slow) disable iff (!por_n)
        done |=> done);
    a_r2_count_in_range: assert property (@(posedge clk_slow) disable iff (!por_n)
        cnt <= LAST);

endmodule

// File: rtl/prst_sync2.sv
// Two-flop synchroniser that carries a level into the destination clock.
// Assumes: d changes at most once per sequence and stays stable afterwards.
module prst_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1;

    // Shift the level through two flops in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end

    a_r2_sync_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(s1));

endmodule

// File: rtl/prst_ost_counter.sv
// Oscillator start-up counter on the crystal clock.
// Once start_ok is seen, counts CYCLES crystal edges in a crystal mode,
// or finishes on the first such edge in RC/external mode.
// A wake pulse in a crystal mode clears the count and starts it again.
// Assumes: xtal is static while por_n is high; wake is a one-cycle pulse.
module prst_ost_counter #(
    parameter int CYCLES = 1024
) (
    input  logic clk_osc,
    input  logic por_n,
    input  logic xtal,
    input  logic wake,
    input  logic start_ok,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Run the start-up count, bypassed in RC/external mode, re-armed on wake.
    always_ff @(posedge clk_osc) begin
        if (!por_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (xtal && wake) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done && start_ok) begin
            if (!xtal)             done <= 1'b1;
            else if (cnt == LAST)  done <= 1'b1;
            else                   cnt  <= cnt + 1'b1;
        end
    end

    a_r7_wake_rearms: assert property (@(posedge clk_osc) disable iff (!por_n)
        (xtal && wake) |=> !done);
    a_r8_rc_wake_ignored: assert property (@(posedge clk_osc) disable iff (!por_n)
        (!xtal && done && wake) |=> done);
    a_r2_release_after_delay: assert property (@(posedge clk_osc) disable iff (!por_n)
        $rose(done) |-> $past(start_ok));
    a_r3_count_in_range: assert property (@(posedge clk_osc) disable iff (!por_n)
        cnt <= LAST);

endmodule

// File: rtl/prst_timeout_seq.sv
// Top of the power-up reset timeout sequencer.
// Chains the slow-tick delay, the synchroniser and the crystal start-up count.
// Gates the result with the external reset pin, with no clocking on that path.
// Assumes: configuration inputs are static while por_n is high; por_n is
// held low across several edges of both clocks.
module prst_timeout_seq
    import prst_pkg::*;
#(
    parameter int PWRT_TICKS = 2048,
    parameter int OST_CYCLES = 1024
) (
    input  logic       clk_slow,
    input  logic       clk_osc,
    input  logic       por_n,
    input  logic       wake,
    input  logic       mclr_n,
    input  logic [1:0] osc_mode,
    input  logic       pwrt_en,
    input  logic       bor_en,
    output logic       core_rst_n
);
    logic delay_on;
    logic xtal;
    logic pwrt_done;
    logic pwrt_done_osc;
    logic ost_done;

    // Brown-out protection forces the delay on; decode the crystal modes.
    always_comb begin
        delay_on = pwrt_en | bor_en;
        xtal     = needs_startup(osc_mode_e'(osc_mode));
    end

    prst_pwrt_timer #(.TICKS(PWRT_TICKS)) u_pwrt (
        .clk_slow (clk_slow),
        .por_n    (por_n),
        .delay_on (delay_on),
        .done     (pwrt_done)
    );

    prst_sync2 u_sync (
        .clk   (clk_osc),
        .rst_n (por_n),
        .d     (pwrt_done),
        .q     (pwrt_done_osc)
    );

    prst_ost_counter #(.CYCLES(OST_CYCLES)) u_ost (
        .clk_osc  (clk_osc),
        .por_n    (por_n),
        .xtal     (xtal),
        .wake     (wake),
        .start_ok (pwrt_done_osc),
        .done     (ost_done)
    );

    // The pin gates release directly, so a late pin rise frees the core at once.
    always_comb core_rst_n = ost_done & mclr_n;

    a_r6_pin_gates_release: assert property (@(posedge clk_osc) disable iff (!por_n)
        core_rst_n |-> mclr_n);
    a_r1_held_until_count: assert property (@(posedge clk_osc) disable iff (!por_n)
        !pwrt_done_osc |-> !core_rst_n);

endmodule

// File: tb/test_prst_timeout_seq.sv
// Scoreboard bench: the driver pushes each expected release edge into a queue,
// and the monitor pops and compares it when core_rst_n rises.
module test_prst_timeout_seq;
    localparam int TICKS = 5;
    localparam int OST   = 1024;

    logic       clk_slow = 1'b0;
    logic       clk_osc  = 1'b0;
    logic       por_n    = 1'b0;
    logic       wake     = 1'b0;
    logic       mclr_n   = 1'b1;
    logic [1:0] osc_mode = 2'b11;
    logic       pwrt_en  = 1'b1;
    logic       bor_en   = 1'b0;
    logic       core_rst_n;

    int    checks = 0;
    int    errors = 0;
    int    osc_cnt = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    mon_en = 1'b1;
    logic  prev = 1'b0;

    prst_timeout_seq #(.PWRT_TICKS(TICKS), .OST_CYCLES(OST)) i_prst_timeout_seq (
        .clk_slow   (clk_slow),
        .clk_osc    (clk_osc),
        .por_n      (por_n),
        .wake       (wake),
        .mclr_n     (mclr_n),
        .osc_mode   (osc_mode),
        .pwrt_en    (pwrt_en),
        .bor_en     (bor_en),
        .core_rst_n (core_rst_n)
    );

    // 50 MHz crystal clock; slow rising edges fall on crystal falling edges.
    always #10 clk_osc = ~clk_osc;
    initial begin
        #20;
        forever begin
            clk_slow = 1'b1; #80;
            clk_slow = 1'b0; #80;
        end
    end

    always @(posedge clk_osc) osc_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: on each rise of core_rst_n, pop one expected edge and compare.
    always @(negedge clk_osc) begin
        if (mon_en && core_rst_n === 1'b1 && prev !== 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected release", osc_cnt, -1);
            end else begin
                check(osc_cnt == exp_q[0], tag_q[0], osc_cnt, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
        prev = core_rst_n;
    end

    // Driver: pulse por_n, then, if asked, push the expected release edge.
    task automatic start_por(input logic [1:0] m, input logic pe, input logic be,
                             input bit push, input string tag);
        int base;
        @(negedge clk_osc); #1;
        por_n = 1'b0;
        osc_mode = m; pwrt_en = pe; bor_en = be;
        repeat (3) @(posedge clk_slow);
        @(negedge clk_osc); #1;
        por_n = 1'b1;
        if (push) begin
            if (pe || be) repeat (TICKS) @(posedge clk_slow);
            base = osc_cnt;
            exp_q.push_back(base + ((m != 2'b11) ? OST + 2 : 3));
            tag_q.push_back(tag);
        end
    endtask

    task automatic wait_release(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 3000) begin
            @(negedge clk_osc);
            n++;
        end
        if (exp_q.size() != 0) begin
            check(1'b0, tag, 0, 1);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int lows;
        // R1: held in reset while por_n is low
        repeat (4) @(posedge clk_slow);
        @(negedge clk_osc);
        check(core_rst_n == 1'b0, "R1 reset state", core_rst_n, 0);

        // R2: delay then RC/external release
        start_por(2'b11, 1'b1, 1'b0, 1'b1, "R2 rc release edge");
        check(core_rst_n == 1'b0, "R1 held through delay", core_rst_n, 0);
        wait_release("R2 no release");

        // R3: each crystal mode
        start_por(2'b00, 1'b1, 1'b0, 1'b1, "R3 lowpwr release edge");
        wait_release("R3 lowpwr no release");
        start_por(2'b01, 1'b1, 1'b0, 1'b1, "R3 xtal release edge");
        wait_release("R3 xtal no release");
        start_por(2'b10, 1'b1, 1'b0, 1'b1, "R3 fast release edge");
        wait_release("R3 fast no release");

        // R4: delay disabled
        start_por(2'b11, 1'b0, 1'b0, 1'b1, "R4 rc no-delay edge");
        wait_release("R4 rc no release");
        start_por(2'b01, 1'b0, 1'b0, 1'b1, "R4 xtal no-delay edge");
        wait_release("R4 xtal no release");

        // R5: brown-out enable forces the delay
        start_por(2'b11, 1'b0, 1'b1, 1'b1, "R5 rc forced delay edge");
        wait_release("R5 rc no release");
        start_por(2'b10, 1'b0, 1'b1, 1'b1, "R5 fast forced delay edge");
        wait_release("R5 fast no release");

        // R9: restart during the delay, then during the crystal count
        start_por(2'b00, 1'b1, 1'b0, 1'b0, "");
        repeat (2) @(posedge clk_slow);
        @(negedge clk_osc);
        check(core_rst_n == 1'b0, "R9 low mid delay", core_rst_n, 0);
        start_por(2'b00, 1'b1, 1'b0, 1'b1, "R9 restart in delay edge");
        wait_release("R9 delay restart no release");
        start_por(2'b01, 1'b1, 1'b0, 1'b0, "");
        repeat (TICKS + 10) @(posedge clk_slow);
        @(negedge clk_osc);
        check(core_rst_n == 1'b0, "R9 low mid count", core_rst_n, 0);
        start_por(2'b01, 1'b1, 1'b0, 1'b1, "R9 restart in count edge");
        wait_release("R9 count restart no release");

        // R7: wake in crystal mode re-runs the count
        @(negedge clk_osc); #1;
        wake = 1'b1;
        @(negedge clk_osc);
        exp_q.push_back(osc_cnt + OST);
        tag_q.push_back("R7 wake release edge");
        check(core_rst_n == 1'b0, "R7 low after wake", core_rst_n, 0);
        #1 wake = 1'b0;
        wait_release("R7 no release");

        // R8: wake ignored in RC/external mode
        start_por(2'b11, 1'b0, 1'b0, 1'b1, "R8 rc setup edge");
        wait_release("R8 setup no release");
        @(negedge clk_osc); #1;
        wake = 1'b1;
        @(negedge clk_osc); #1;
        wake = 1'b0;
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_osc);
            if (core_rst_n !== 1'b1) lows++;
        end
        check(lows == 0, "R8 wake ignored", lows, 0);

        // R6: pin held low past both waits, then raised
        mclr_n = 1'b0;
        start_por(2'b11, 1'b0, 1'b0, 1'b0, "");
        repeat (50) @(negedge clk_osc);
        check(core_rst_n == 1'b0, "R6 pin holds reset", core_rst_n, 0);
        mon_en = 1'b0;
        #1 mclr_n = 1'b1;
        #1 check(core_rst_n == 1'b1, "R6 immediate release", core_rst_n, 1);
        #1 mclr_n = 1'b0;
        #1 check(core_rst_n == 1'b0, "R6 pin reasserts", core_rst_n, 0);
        #1 mclr_n = 1'b1;
        @(negedge clk_osc);
        @(negedge clk_osc);
        mon_en = 1'b1;

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule